// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the host-facing register set of a legacy keyboard controller. A host processor and an embedded controller CPU pass bytes to each other through two one-byte mailboxes. The host writes into an input data register and reads from an output data register. The CPU does the reverse. Both sides also see a shared status byte. Two handshake flags in that byte are set and cleared by the accesses themselves, so neither side ever writes them. Each host write is also tagged as a command or as data, depending on the host address bit.

The host port has a chip select, read and write strobes, and one address bit. With the address bit at 0 the host reaches the data registers; at 1 it reaches command/status. The CPU port has separate strobes for reading the input data register, writing the output data register, writing the status byte and writing a control byte. The CPU can always see the input data and the status byte on dedicated outputs. An interrupt tells the CPU that a host byte is waiting.

Two reset sources exist. The first is an asynchronous active-low reset that is released synchronously. The second is a synchronous reset request that takes effect only after it has been held for a minimum number of clock periods, 24 by default.

Top module: `kbc_mailbox`

## Requirements
- R1: A CPU output-data write (`cpu_out_wr`) loads `cpu_wdata` into the output data register and sets status bit 0 (output full) on the next clock edge.
- R2: A host data read (`host_cs` and `host_rd` with `host_a`=0) clears status bit 0 at the clock edge that ends the read. If a CPU output-data write happens in the same cycle, bit 0 stays set.
- R3: A host write (`host_cs` and `host_wr`) loads `host_wdata` into the input data register and sets status bit 1 (input full). A CPU read (`cpu_in_rd`) clears bit 1. If both happen in the same cycle, bit 1 stays set.
- R4: On every host write, status bit 3 takes the value of `host_a`: 1 marks a command and 0 marks data.
- R5: `cpu_irq` is high exactly when status bit 1 is set and the interrupt enable is set. The enable is loaded from `cpu_wdata[0]` by `cpu_ctl_wr` and is 0 after reset.
- R6: A CPU status write (`cpu_stat_wr`) updates only the user bits 2 and 7:4 from `cpu_wdata`. Bits 0, 1 and 3 are left unchanged.
- R7: While `host_cs` and `host_rd` are high, `host_rdata` shows the output data register when `host_a`=0 and the status byte when `host_a`=1. Otherwise it reads 00h. A host write with `host_a`=1 never changes the user status bits.
- R8: While `rst_n` is low, the status byte, both data registers and the interrupt enable are 00h/0.
- R9: `rst_req` held high for `RST_MIN` consecutive clock edges clears the same state as R8 at the `RST_MIN`-th edge. A pulse that is one edge shorter changes nothing.
- R10: A host write while bit 1 is already set overwrites the input data register and updates bit 3. Bit 1 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req | input | 1 | Filtered synchronous reset request, active high |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_a | input | 1 | Host address bit: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| cpu_in_rd | input | 1 | CPU reads the input data register |
| cpu_out_wr | input | 1 | CPU writes the output data register |
| cpu_stat_wr | input | 1 | CPU writes the user status bits |
| cpu_ctl_wr | input | 1 | CPU writes the control byte (bit 0 is the interrupt enable) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_in_data | output | 8 | Input data register contents |
| cpu_status | output | 8 | Status byte |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Every piece of internal state in this block appears at the ports one clock edge after it changes. The flags and the command bit show up on `cpu_status`, and the data registers show up on `cpu_in_data` or on a host read. A flag that sticks or fails to set therefore shows at the very next edge. The bench checks each flag at that edge, and it also checks the same-cycle races in which set and clear meet. A wrong interrupt enable shows only while the input-full flag is set, so that case is checked with a byte pending. A reset filter whose count is off by one is caught by comparing a pulse of exactly the minimum length with a pulse one edge shorter.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DW          = 8;
  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_CMD      = 3;
  localparam logic [DW-1:0] ST_USER_MASK = 8'hF4;
endpackage

// File: rtl/kbc_rst_ctl.sv
module kbc_rst_ctl #(
  parameter int RST_MIN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  output logic rst_n_sync,
  output logic sreset
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(RST_MIN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_req)             cnt_d = '0;
    else if (cnt_q < CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign sreset = rst_req && (cnt_q >= CNT_TOP);
endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sreset,
  input  logic          host_wr_ev,
  input  logic          host_rd_data_ev,
  input  logic          host_a,
  input  logic [DW-1:0] host_wdata,
  input  logic          cpu_in_rd,
  input  logic          cpu_out_wr,
  input  logic          cpu_stat_wr,
  input  logic          cpu_ctl_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] status,
  output logic          irq_en
);
  logic [DW-1:0] in_q, in_d, out_q, out_d, user_q, user_d;
  logic          obf_q, obf_d, ibf_q, ibf_d, cmd_q, cmd_d, en_q, en_d;

  always_comb begin
    in_d   = in_q;
    out_d  = out_q;
    user_d = user_q;
    obf_d  = obf_q;
    ibf_d  = ibf_q;
    cmd_d  = cmd_q;
    en_d   = en_q;
    if (host_rd_data_ev) obf_d = 1'b0;
    if (cpu_out_wr) begin
      out_d = cpu_wdata;
      obf_d = 1'b1;
    end
    if (cpu_in_rd) ibf_d = 1'b0;
    if (host_wr_ev) begin
      in_d  = host_wdata;
      ibf_d = 1'b1;
      cmd_d = host_a;
    end
    if (cpu_stat_wr) user_d = cpu_wdata & ST_USER_MASK;
    if (cpu_ctl_wr)  en_d   = cpu_wdata[0];
    if (sreset) begin
      in_d   = '0;
      out_d  = '0;
      user_d = '0;
      obf_d  = 1'b0;
      ibf_d  = 1'b0;
      cmd_d  = 1'b0;
      en_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      user_q <= '0;
      obf_q  <= 1'b0;
      ibf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      in_q   <= in_d;
      out_q  <= out_d;
      user_q <= user_d;
      obf_q  <= obf_d;
      ibf_q  <= ibf_d;
      cmd_q  <= cmd_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    status              = user_q & ST_USER_MASK;
    status[ST_OUT_FULL] = obf_q;
    status[ST_IN_FULL]  = ibf_q;
    status[ST_CMD]      = cmd_q;
  end

  assign in_data  = in_q;
  assign out_data = out_q;
  assign irq_en   = en_q;
endmodule

// File: rtl/kbc_host_mux.sv
module kbc_host_mux
  import kbc_pkg::*;
(
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_a,
  input  logic [DW-1:0] out_data,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] host_rdata
);
  always_comb begin
    host_rdata = '0;
    if (host_cs && host_rd) host_rdata = host_a ? status : out_data;
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int RST_MIN = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_req,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_a,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cpu_in_rd,
  input  logic          cpu_out_wr,
  input  logic          cpu_stat_wr,
  input  logic          cpu_ctl_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_in_data,
  output logic [DW-1:0] cpu_status,
  output logic          cpu_irq
);
  logic          rst_n_sync, sreset, irq_en;
  logic          host_wr_ev, host_rd_data_ev;
  logic [DW-1:0] out_data, status;

  assign host_wr_ev      = host_cs && host_wr;
  assign host_rd_data_ev = host_cs && host_rd && !host_a;

  kbc_rst_ctl #(.RST_MIN(RST_MIN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .rst_n_sync(rst_n_sync), .sreset(sreset)
  );

  kbc_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync), .sreset(sreset),
    .host_wr_ev(host_wr_ev), .host_rd_data_ev(host_rd_data_ev),
    .host_a(host_a), .host_wdata(host_wdata),
    .cpu_in_rd(cpu_in_rd), .cpu_out_wr(cpu_out_wr),
    .cpu_stat_wr(cpu_stat_wr), .cpu_ctl_wr(cpu_ctl_wr),
    .cpu_wdata(cpu_wdata),
    .in_data(cpu_in_data), .out_data(out_data),
    .status(status), .irq_en(irq_en)
  );

  kbc_host_mux u_mux (
    .host_cs(host_cs), .host_rd(host_rd), .host_a(host_a),
    .out_data(out_data), .status(status), .host_rdata(host_rdata)
  );

  assign cpu_status = status;
  assign cpu_irq    = status[ST_IN_FULL] && irq_en;
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
  input logic       clk,
  input logic       rst_n_sync,
  input logic       sreset,
  input logic       host_cs,
  input logic       host_rd,
  input logic       host_wr,
  input logic       host_a,
  input logic       cpu_in_rd,
  input logic       cpu_out_wr,
  input logic       cpu_stat_wr,
  input logic [7:0] cpu_status,
  input logic       cpu_irq
);
  AST_OUT_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    cpu_out_wr |=> cpu_status[0]); // R1
  AST_OUT_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    (host_cs && host_rd && !host_a && !cpu_out_wr) |=> !cpu_status[0]); // R2
  AST_IN_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    (host_cs && host_wr) |=> cpu_status[1]); // R3
  AST_IN_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    (cpu_in_rd && !(host_cs && host_wr)) |=> !cpu_status[1]); // R3
  AST_CMD_TAG: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    (host_cs && host_wr) |=> (cpu_status[3] == $past(host_a))); // R4
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cpu_irq |-> cpu_status[1]); // R5
  AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync || sreset)
    !cpu_stat_wr |=> ((cpu_status & 8'hF4) == ($past(cpu_status) & 8'hF4))); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    sreset |=> (cpu_status == 8'h00)); // R9
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .sreset(sreset),
  .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr), .host_a(host_a),
  .cpu_in_rd(cpu_in_rd), .cpu_out_wr(cpu_out_wr), .cpu_stat_wr(cpu_stat_wr),
  .cpu_status(cpu_status), .cpu_irq(cpu_irq)
);

// File: tb/test_kbc_mailbox.sv
module test_kbc_mailbox;
  logic       clk = 1'b0;
  logic       rst_n, rst_req;
  logic       host_cs, host_rd, host_wr, host_a;
  logic [7:0] host_wdata, host_rdata;
  logic       cpu_in_rd, cpu_out_wr, cpu_stat_wr, cpu_ctl_wr;
  logic [7:0] cpu_wdata, cpu_in_data, cpu_status;
  logic       cpu_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbc_mailbox #(.RST_MIN(24)) i_kbc_mailbox (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr), .host_a(host_a),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_in_rd(cpu_in_rd), .cpu_out_wr(cpu_out_wr), .cpu_stat_wr(cpu_stat_wr),
    .cpu_ctl_wr(cpu_ctl_wr), .cpu_wdata(cpu_wdata),
    .cpu_in_data(cpu_in_data), .cpu_status(cpu_status), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_cs = 0; host_rd = 0; host_wr = 0; host_a = 0; host_wdata = 0;
    cpu_in_rd = 0; cpu_out_wr = 0; cpu_stat_wr = 0; cpu_ctl_wr = 0; cpu_wdata = 0;
  endtask

  // one-cycle host write, ends at a negedge after the capturing edge
  task automatic host_write(input logic a, input logic [7:0] d);
    host_cs = 1; host_wr = 1; host_a = a; host_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    host_cs = 1; host_rd = 1; host_a = a;
    #1 d = host_rdata;
    @(negedge clk); idle();
  endtask

  task automatic cpu_op(input logic out_wr, input logic in_rd, input logic st_wr,
                        input logic ctl_wr, input logic [7:0] d);
    cpu_out_wr = out_wr; cpu_in_rd = in_rd; cpu_stat_wr = st_wr; cpu_ctl_wr = ctl_wr;
    cpu_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic do_hw_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R8 status after reset", cpu_status, 8'h00);
    chk("R8 irq after reset", {7'b0, cpu_irq}, 8'h00);
    chk("R7 idle host_rdata", host_rdata, 8'h00);
    host_read(1'b0, d);
    chk("R8 output data after reset", d, 8'h00);
  endtask

  task automatic t_out_path();
    logic [7:0] d;
    cpu_op(1, 0, 0, 0, 8'hA5);
    chk("R1 out full set", cpu_status & 8'h01, 8'h01);
    host_read(1'b0, d);
    chk("R1 R7 host reads output data", d, 8'hA5);
    chk("R2 out full cleared by host read", cpu_status & 8'h01, 8'h00);
    cpu_out_wr = 1; cpu_wdata = 8'h5A;
    host_read(1'b0, d);
    chk("R2 race old data returned", d, 8'hA5);
    chk("R2 race flag stays set", cpu_status & 8'h01, 8'h01);
    host_read(1'b0, d);
    chk("R2 race new data", d, 8'h5A);
  endtask

  task automatic t_in_path();
    host_write(1'b0, 8'h3C);
    chk("R3 in data captured", cpu_in_data, 8'h3C);
    chk("R3 R4 status data byte", cpu_status, 8'h02);
    chk("R5 irq masked", {7'b0, cpu_irq}, 8'h00);
    cpu_op(0, 0, 0, 1, 8'h01);
    chk("R5 irq enabled", {7'b0, cpu_irq}, 8'h01);
    cpu_op(0, 1, 0, 0, 8'h00);
    chk("R3 in full cleared", cpu_status & 8'h02, 8'h00);
    chk("R5 irq drops", {7'b0, cpu_irq}, 8'h00);
    host_cs = 1; host_wr = 1; host_a = 0; host_wdata = 8'h77; cpu_in_rd = 1;
    @(negedge clk); idle();
    chk("R3 race write wins", cpu_status & 8'h02, 8'h02);
    cpu_op(0, 1, 0, 0, 8'h00);
  endtask

  task automatic t_cmd_overwrite();
    logic [7:0] d;
    host_write(1'b1, 8'hD1);
    chk("R4 command tag", cpu_status & 8'h08, 8'h08);
    host_read(1'b1, d);
    chk("R7 host status read", d, 8'h0A);
    host_write(1'b0, 8'h55);
    chk("R10 overwrite data", cpu_in_data, 8'h55);
    chk("R10 flag kept, tag data", cpu_status, 8'h02);
    cpu_op(0, 1, 0, 0, 8'h00);
  endtask

  task automatic t_user_bits();
    cpu_op(1, 0, 0, 0, 8'h11);
    cpu_op(0, 0, 1, 0, 8'hFF);
    chk("R6 user bits written, flags kept", cpu_status, 8'hF5);
    cpu_op(0, 0, 1, 0, 8'h0B);
    chk("R6 flag bits not writable", cpu_status, 8'h01);
    cpu_op(0, 0, 1, 0, 8'hA4);
    host_write(1'b1, 8'h00);
    chk("R7 host write leaves user bits", cpu_status, 8'hAF);
  endtask

  task automatic t_soft_reset();
    rst_req = 1;
    repeat (23) @(negedge clk);
    rst_req = 0;
    @(negedge clk);
    chk("R9 short pulse ignored", cpu_status, 8'hAF);
    chk("R9 short pulse keeps data", cpu_in_data, 8'h00);
    rst_req = 1;
    repeat (23) @(negedge clk);
    chk("R9 one edge early", cpu_status, 8'hAF);
    @(negedge clk);
    rst_req = 0;
    chk("R9 full pulse clears", cpu_status, 8'h00);
    chk("R9 irq cleared", {7'b0, cpu_irq}, 8'h00);
  endtask

  task automatic t_hw_reset();
    host_write(1'b0, 8'h99);
    cpu_op(0, 0, 0, 1, 8'h01);
    chk("R5 irq before reset", {7'b0, cpu_irq}, 8'h01);
    rst_n = 0;
    #1;
    chk("R8 async clear status", cpu_status, 8'h00);
    chk("R8 async clear in data", cpu_in_data, 8'h00);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    host_write(1'b0, 8'h12);
    chk("R5 enable cleared by reset", {7'b0, cpu_irq}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_req = 0;
    @(negedge clk);
    do_hw_reset();
    t_reset();
    t_out_path();
    t_in_path();
    t_cmd_overwrite();
    t_user_bits();
    t_soft_reset();
    t_hw_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule